// File: doc/BRIEF.md
# Bit-Oriented Code Receive Detector

This block monitors a serial data-link bit stream for repeating bit-oriented code messages. Each message is a 16-bit pattern: a flag of eight ones, a zero, six code bits and a closing zero. The detector finds pattern boundaries without any framing help by searching a sliding window on every valid bit. It declares a code valid once enough identical, correctly formed patterns have arrived back to back. It then watches for the code to go away and raises a one-cycle cleared pulse after a programmable run of message bits passes with no matching pattern.

The detector is always in exactly one of two modes. While integrating, it counts matching patterns. While disintegrating, it counts bits that carry no valid pattern. The host chooses the filter depth and the loss window through two select fields. These selects reach the detector only when an acknowledged reset completes. The reset is started by a request pulse and stays busy for a fixed number of cycles, unless a global initialisation-done input ends it early.

Top module: `boc_rx_detector`

## Requirements
- R1: A pattern is 8 ones, a 0, six code bits and a 0, in arrival order. The first code bit to arrive becomes `code_out[5]`. With latched filter select 00, 01, 10 or 11, `code_valid` rises on the cycle after the bit that completes the 1st, 3rd, 5th or 7th identical consecutive pattern, and `code_out` then shows that code.
- R2: While integrating, a pattern whose code differs from the code being counted restarts the count at 1 with the new code.
- R3: With latched loss select 00, 01, 10 or 11, `code_clear` pulses for one cycle and `code_valid` falls in the same cycle. This happens after 16, 32, 48 or 64 valid bits have passed since the last matching pattern.
- R4: While a code is valid, a pattern carrying the same code restarts the bit count, so back-to-back repeats keep the code valid indefinitely.
- R5: Integration and disintegration never overlap. While a code is valid, a pattern with a different code is not integrated; it only adds to the loss count. `code_out` holds its value after a clear until a new code is validated.
- R6: A one-cycle `rst_req` makes `rst_busy` high for exactly RST_CYCLES cycles. While busy, input bits are ignored. When the reset completes, `code_valid` is 0 and `code_out` is 0.
- R7: Changes to `filt_sel` and `disint_sel` have no effect until a reset completes. Until then the previously latched values stay in use.
- R8: `init_done` asserted while busy ends the reset on the next cycle.
- R9: After `rst_n` the outputs are 0 and both latched selects are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_vld | input | 1 | Strobe: `bit_in` carries a data-link bit this cycle |
| bit_in | input | 1 | Serial data-link bit |
| filt_sel | input | 2 | Requested filter depth select |
| disint_sel | input | 2 | Requested loss window select |
| rst_req | input | 1 | One-cycle request to start a detector reset |
| init_done | input | 1 | Global initialisation done; ends a pending reset |
| code_out | output | 6 | Last validated code |
| code_valid | output | 1 | Level: a code is currently valid |
| code_clear | output | 1 | One-cycle pulse: the valid code was lost |
| rst_busy | output | 1 | Reset in progress |

## Verification
The assertions assume that `rst_req` and `init_done` are single-cycle pulses. They also assume that `init_done` only matters while a reset is pending, and that the selects are sampled solely at reset completion. The bench respects this. It drives every control input on the falling clock edge, pulses requests for one cycle, and sends patterns only after `rst_busy` has dropped, except in the one test meant to show that bits sent during busy are ignored. Bits are streamed with `bit_vld` held high so that pattern and bit counts match the windows exactly.

// File: rtl/boc_pkg.sv
// Shared types and helpers for the bit-oriented code receive detector.
// Assumes a fixed four-entry mapping of the filter select to pattern counts.
package boc_pkg;

    typedef enum logic {
        MODE_INTEG  = 1'b0,
        MODE_DISINT = 1'b1
    } boc_mode_e;

    // Number of identical consecutive patterns required for a given select.
    function automatic logic [2:0] filt_need(input logic [1:0] sel);
        logic [2:0] n;
        case (sel)
            2'b00:   n = 3'd1;
            2'b01:   n = 3'd3;
            2'b10:   n = 3'd5;
            default: n = 3'd7;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/boc_reset_ctrl.sv
// Acknowledged reset sequencer. A request pulse starts a busy window of
// RST_CYCLES cycles (or shorter if init_done arrives). The requested selects
// are copied into the working configuration only when the window ends.
// Assumes rst_req is ignored while a reset is already in progress.
module boc_reset_ctrl #(
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req,
    input  logic       init_done,
    input  logic [1:0] filt_sel,
    input  logic [1:0] disint_sel,
    output logic       busy,
    output logic [1:0] filt_cfg,
    output logic [1:0] disint_cfg
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             last_cycle;

    // Detect the final cycle of the busy window.
    always_comb begin
        last_cycle = init_done || (cnt_q == CNT_W'(RST_CYCLES - 1));
    end

    // Busy window sequencing and configuration latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cnt_q      <= '0;
            filt_cfg   <= 2'b00;
            disint_cfg <= 2'b00;
        end else if (busy) begin
            if (last_cycle) begin
                busy       <= 1'b0;
                cnt_q      <= '0;
                filt_cfg   <= filt_sel;
                disint_cfg <= disint_sel;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (rst_req) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/boc_pattern_finder.sv
// Sliding-window pattern search. On every valid bit, the last PAT_W bits are
// tested for flag (FLAG_W ones), zero, CODE_W code bits, zero. No alignment
// state is kept: the flag cannot occur inside a well-formed pattern's body.
// Assumes clr holds the window empty.
module boc_pattern_finder #(
    parameter int CODE_W = 6,
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              pat_hit,
    output logic [CODE_W-1:0] pat_code
);

    localparam int PAT_W = FLAG_W + CODE_W + 2;

    logic [PAT_W-2:0] win_q;
    logic [PAT_W-1:0] win_nxt;

    // Window as it will look after the current bit is shifted in.
    always_comb begin
        win_nxt  = {win_q, bit_in};
        pat_code = win_nxt[CODE_W:1];
        pat_hit  = bit_vld
                && (win_nxt[PAT_W-1 -: FLAG_W] == {FLAG_W{1'b1}})
                && !win_nxt[CODE_W+1]
                && !win_nxt[0];
    end

    // Shift register holding the most recent bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win_q <= '0;
        end else if (bit_vld) begin
            win_q <= win_nxt[PAT_W-2:0];
        end
    end

endmodule

// File: rtl/boc_integrator.sv
// Two-mode detector core. In integration mode it counts identical
// consecutive patterns until the filter depth is met. In disintegration mode
// it counts valid bits since the last matching pattern until the loss window
// expires. Only one counter is active at a time.
// Assumes filt_cfg and disint_cfg change only while clr is asserted.
module boc_integrator
    import boc_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int DIS_STEP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              pat_hit,
    input  logic [CODE_W-1:0] pat_code,
    input  logic [1:0]        filt_cfg,
    input  logic [1:0]        disint_cfg,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid,
    output logic              code_clear
);

    localparam int BCNT_W = $clog2(4 * DIS_STEP + 1);

    boc_mode_e         mode_q;
    logic [CODE_W-1:0] cand_q;
    logic [2:0]        icnt_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic [2:0]        need;
    logic [2:0]        icnt_nxt;
    logic [BCNT_W-1:0] limit;
    logic [BCNT_W-1:0] bcnt_inc;
    logic              same_code;

    // Thresholds and next counts for the active mode.
    always_comb begin
        need      = filt_need(filt_cfg);
        limit     = BCNT_W'((32'(disint_cfg) + 32'd1) * 32'(DIS_STEP));
        icnt_nxt  = ((pat_code == cand_q) && (icnt_q != 3'd0)) ? icnt_q + 3'd1 : 3'd1;
        bcnt_inc  = bcnt_q + 1'b1;
        same_code = pat_hit && (pat_code == code_out);
    end

    // Mode sequencing, counters and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mode_q     <= MODE_INTEG;
            cand_q     <= '0;
            icnt_q     <= '0;
            bcnt_q     <= '0;
            code_out   <= '0;
            code_valid <= 1'b0;
            code_clear <= 1'b0;
        end else begin
            code_clear <= 1'b0;
            if (mode_q == MODE_INTEG) begin
                if (pat_hit) begin
                    cand_q <= pat_code;
                    if (icnt_nxt >= need) begin
                        icnt_q     <= '0;
                        bcnt_q     <= '0;
                        code_out   <= pat_code;
                        code_valid <= 1'b1;
                        mode_q     <= MODE_DISINT;
                    end else begin
                        icnt_q <= icnt_nxt;
                    end
                end
            end else if (bit_vld) begin
                if (same_code) begin
                    bcnt_q <= '0;
                end else if (bcnt_inc == limit) begin
                    bcnt_q     <= '0;
                    code_valid <= 1'b0;
                    code_clear <= 1'b1;
                    mode_q     <= MODE_INTEG;
                end else begin
                    bcnt_q <= bcnt_inc;
                end
            end
        end
    end

endmodule

// File: rtl/boc_rx_detector.sv
// Top level of the bit-oriented code receive detector. Connects the reset
// sequencer, the pattern search and the two-mode detector core.
// Assumes one data-link bit per cycle at most, flagged by bit_vld.
module boc_rx_detector #(
    parameter int CODE_W     = 6,
    parameter int FLAG_W     = 8,
    parameter int DIS_STEP   = 16,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic [1:0]        filt_sel,
    input  logic [1:0]        disint_sel,
    input  logic              rst_req,
    input  logic              init_done,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid,
    output logic              code_clear,
    output logic              rst_busy
);

    logic [1:0]        filt_cfg;
    logic [1:0]        disint_cfg;
    logic              pat_hit;
    logic [CODE_W-1:0] pat_code;

    boc_reset_ctrl #(
        .RST_CYCLES(RST_CYCLES)
    ) rst_ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req   (rst_req),
        .init_done (init_done),
        .filt_sel  (filt_sel),
        .disint_sel(disint_sel),
        .busy      (rst_busy),
        .filt_cfg  (filt_cfg),
        .disint_cfg(disint_cfg)
    );

    boc_pattern_finder #(
        .CODE_W(CODE_W),
        .FLAG_W(FLAG_W)
    ) finder_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rst_busy),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .pat_hit (pat_hit),
        .pat_code(pat_code)
    );

    boc_integrator #(
        .CODE_W  (CODE_W),
        .DIS_STEP(DIS_STEP)
    ) integ_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rst_busy),
        .bit_vld   (bit_vld),
        .pat_hit   (pat_hit),
        .pat_code  (pat_code),
        .filt_cfg  (filt_cfg),
        .disint_cfg(disint_cfg),
        .code_out  (code_out),
        .code_valid(code_valid),
        .code_clear(code_clear)
    );

endmodule

// File: rtl/boc_rx_detector_chk.sv
// Property checker for the detector, attached to every instance of the top
// module by the bind statement below. Assumes rst_req and init_done are
// single-cycle pulses.
module boc_rx_detector_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_vld,
    input logic              init_done,
    input logic [CODE_W-1:0] code_out,
    input logic              code_valid,
    input logic              code_clear,
    input logic              rst_busy,
    input logic [1:0]        filt_cfg,
    input logic [1:0]        disint_cfg
);

    // A code can only become valid on the cycle after a data bit.
    assert_valid_after_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> $past(bit_vld));

    // The cleared event is a single-cycle pulse.
    assert_clear_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        code_clear |=> !code_clear);

    // Valid falls in the same cycle the cleared pulse appears.
    assert_clear_drops_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        code_clear |-> (!code_valid && $past(code_valid)));

    // The reported code does not move while it stays valid.
    assert_code_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && $past(code_valid)) |-> $stable(code_out));

    // During a reset the detector output is held cleared.
    assert_busy_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_busy && $past(rst_busy)) |-> (!code_valid && code_out == '0));

    // The working configuration changes only when a reset completes.
    assert_cfg_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(rst_busy) |-> ($stable(filt_cfg) && $stable(disint_cfg)));

    // Initialisation done ends a pending reset at once.
    assert_init_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_busy && init_done) |=> !rst_busy);

endmodule

bind boc_rx_detector boc_rx_detector_chk #(.CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .init_done (init_done),
    .code_out  (code_out),
    .code_valid(code_valid),
    .code_clear(code_clear),
    .rst_busy  (rst_busy),
    .filt_cfg  (filt_cfg),
    .disint_cfg(disint_cfg)
);

// File: tb/boc_rx_detector_tb_top.sv
module boc_rx_detector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 16;
    localparam int STEP       = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_vld;
    logic       bit_in;
    logic [1:0] filt_sel;
    logic [1:0] disint_sel;
    logic       rst_req;
    logic       init_done;
    logic [5:0] code_out;
    logic       code_valid;
    logic       code_clear;
    logic       rst_busy;

    int checks   = 0;
    int failures = 0;
    bit seen_clear;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    boc_rx_detector #(
        .CODE_W(6), .FLAG_W(8), .DIS_STEP(STEP), .RST_CYCLES(RST_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .filt_sel(filt_sel), .disint_sel(disint_sel), .rst_req(rst_req),
        .init_done(init_done), .code_out(code_out), .code_valid(code_valid),
        .code_clear(code_clear), .rst_busy(rst_busy)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (code_clear) seen_clear = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        bit_vld = 1'b1;
        bit_in  = b;
        tick();
        bit_vld = 1'b0;
        bit_in  = 1'b0;
    endtask

    task automatic send_pat(input logic [5:0] c);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 5; i >= 0; i--) send_bit(c[i]);
        send_bit(1'b0);
    endtask

    task automatic apply_cfg(input logic [1:0] f, input logic [1:0] d);
        filt_sel   = f;
        disint_sel = d;
        rst_req    = 1'b1;
        tick();
        rst_req = 1'b0;
        while (rst_busy) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; filt_sel = 2'b00;
        disint_sel = 2'b00; rst_req = 1'b0; init_done = 1'b0; seen_clear = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R9: reset state
        check_eq("R9", "code_valid", code_valid, 0);
        check_eq("R9", "code_clear", code_clear, 0);
        check_eq("R9", "rst_busy", rst_busy, 0);
        check_eq("R9", "code_out", code_out, 0);
        // R9: latched filter 00 means a single pattern validates
        send_pat(6'h15);
        check_eq("R9", "valid with default filter", code_valid, 1);

        // R6: busy length and clearing
        begin
            int n = 0;
            rst_req = 1'b1; tick(); rst_req = 1'b0;
            while (rst_busy) begin n++; tick(); end
            check_eq("R6", "busy cycles", n, RST_CYC);
            check_eq("R6", "valid after reset", code_valid, 0);
            check_eq("R6", "code after reset", code_out, 0);
        end
        // R6: a pattern sent while busy is ignored
        rst_req = 1'b1; tick(); rst_req = 1'b0;
        send_pat(6'h2A);
        check_eq("R6", "busy done after ignored pattern", rst_busy, 0);
        check_eq("R6", "pattern during busy ignored", code_valid, 0);

        // R8: init_done ends a pending reset
        rst_req = 1'b1; tick(); rst_req = 1'b0;
        init_done = 1'b1; tick(); init_done = 1'b0;
        check_eq("R8", "busy after init_done", rst_busy, 0);

        // R1 / R3 sweep over every filter and loss select
        for (int f = 0; f < 4; f++) begin
            for (int d = 0; d < 4; d++) begin
                logic [5:0] c;
                int need;
                int lim;
                c    = 6'(f * 4 + d + 5);
                need = (f == 0) ? 1 : 2 * f + 1;
                lim  = STEP * (d + 1);
                apply_cfg(2'(f), 2'(d));
                for (int p = 1; p <= need; p++) begin
                    send_pat(c);
                    check_eq("R1", "valid after pattern", code_valid, (p == need) ? 1 : 0);
                end
                check_eq("R1", "code_out", code_out, c);
                seen_clear = 1'b0;
                for (int k = 1; k < lim; k++) send_bit(1'b0);
                check_eq("R3", "valid before window end", code_valid, 1);
                check_eq("R3", "no early clear", seen_clear, 0);
                send_bit(1'b0);
                check_eq("R3", "clear at window end", code_clear, 1);
                check_eq("R3", "valid dropped", code_valid, 0);
                check_eq("R5", "code held after clear", code_out, c);
                tick();
                check_eq("R3", "clear one cycle", code_clear, 0);
            end
        end

        // R2: code change restarts integration
        apply_cfg(2'b11, 2'b00);
        for (int p = 0; p < 3; p++) send_pat(6'h0C);
        for (int p = 0; p < 6; p++) send_pat(6'h33);
        check_eq("R2", "not valid after 6 of new code", code_valid, 0);
        send_pat(6'h33);
        check_eq("R2", "valid after 7 of new code", code_valid, 1);
        check_eq("R2", "code_out new code", code_out, 6'h33);

        // R4: back-to-back repeats keep the code valid
        seen_clear = 1'b0;
        for (int p = 0; p < 20; p++) send_pat(6'h33);
        check_eq("R4", "still valid", code_valid, 1);
        check_eq("R4", "no clear during repeats", seen_clear, 0);
        // R4: a different code does not refresh the window
        send_pat(6'h0C);
        check_eq("R4", "clear on foreign pattern", code_clear, 1);
        check_eq("R5", "code held", code_out, 6'h33);

        // R5: no integration while disintegrating
        apply_cfg(2'b00, 2'b00);
        send_pat(6'h11);
        check_eq("R5", "valid first code", code_valid, 1);
        send_pat(6'h22);
        check_eq("R5", "foreign pattern not integrated", code_valid, 0);
        check_eq("R5", "code not replaced", code_out, 6'h11);
        send_pat(6'h22);
        check_eq("R5", "integration resumes", code_valid, 1);
        check_eq("R5", "new code reported", code_out, 6'h22);

        // R7: select changes need a completed reset
        apply_cfg(2'b01, 2'b00);
        filt_sel = 2'b11;
        for (int p = 0; p < 3; p++) send_pat(6'h07);
        check_eq("R7", "old filter still used", code_valid, 1);
        apply_cfg(2'b11, 2'b00);
        for (int p = 0; p < 3; p++) send_pat(6'h07);
        check_eq("R7", "new filter after reset, 3 patterns", code_valid, 0);
        for (int p = 0; p < 4; p++) send_pat(6'h07);
        check_eq("R7", "new filter after reset, 7 patterns", code_valid, 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule